// File: doc/BRIEF.md
# Masked Vector Tuple Broadcast Unit

This block is one registered stage of a vector datapath. It accepts a source operand of up to 256 bits and a set of control fields. From these it builds a destination vector of 128, 256 or 512 bits. It takes a short tuple of 1, 2, 4 or 8 elements from the low end of the source, with elements of 32 or 64 bits, and repeats that tuple across every element lane of the active length. In the masked form, a per-lane write mask picks the lanes that take the repeated value. Each lane that is not picked either keeps its previous value (merge) or is cleared (zero). Every destination bit above the active length is cleared.

The unit keeps its own destination register, and that register is the "previous value" that merge mode preserves. Some combinations of length, element width, tuple count, source kind and reserved field are illegal. For those, the unit raises an illegal flag on the result and leaves the destination unchanged.

Operations enter on a valid/ready handshake, and results leave on a second valid/ready handshake. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` one cycle later. `in_ready` is high whenever no result is pending or the pending result is being taken (`out_ready` high) in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flag hold steady and no new operation is accepted.

Top module: `vec_bcast_unit`

## Requirements
- R1: With 32-bit elements (`elem64`=0), destination lane j receives source element (j mod T). T is 1, 2, 4 or 8 for `tup_sel` = 0, 1, 2, 3. Source element e occupies bits [32e+31:32e].
- R2: With 64-bit elements (`elem64`=1), the unit accepts T = 1, 2 or 4. Lane j (bits [64j+63:64j]) receives source bits [64n+63:64n], where n = j mod T.
- R3: In the masked form (`masked`=1) with `zero_mode`=0, a lane whose mask bit is 0 keeps its previous destination value.
- R4: In the masked form with `zero_mode`=1, a lane whose mask bit is 0 is written with zeros.
- R5: In the unmasked form (`masked`=0), every active lane receives the broadcast value whatever the mask and `zero_mode` inputs hold.
- R6: `len_sel` = 0, 1, 2 selects an active length of 128, 256 or 512 bits. Lane count = length / element width. Destination bits above the active length are zero after a legal operation. Mask bits at or above the lane count have no effect.
- R7: At 128-bit length, a 64-bit single-element broadcast and any 2- or 4-element tuple are illegal. `len_sel`=3 is illegal at any width.
- R8: A tuple of 256 bits (8 x 32 or 4 x 64) is legal only at 512-bit length. A 512-bit tuple (8 x 64) is always illegal.
- R9: The 4-bit reserved field `rsv` must equal 4'b1111. Any other value is illegal.
- R10: In the unmasked form with `reg_src`=1, a 64-bit single-element broadcast and a 128-bit tuple (4 x 32 or 2 x 64) are illegal. A 32-bit single-element broadcast from a register stays legal.
- R11: An accepted operation yields `out_valid` on the next cycle. An illegal operation sets `out_illegal` and leaves `dst_data` unchanged. After reset, `dst_data` is zero and `out_valid` is low.
- R12: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `dst_data`, `out_illegal` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| src_data | input | 256 | Source operand; tuple taken from its low end |
| len_sel | input | 2 | Active length: 0=128, 1=256, 2=512, 3=illegal |
| tup_sel | input | 2 | Tuple count: 0=1, 1=2, 2=4, 3=8 elements |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit |
| masked | input | 1 | 1 = write mask applies |
| zero_mode | input | 1 | 1 = clear unselected lanes, 0 = keep them |
| reg_src | input | 1 | 1 = source came from a register |
| rsv | input | 4 | Reserved field, must be 4'b1111 |
| lane_mask | input | 16 | Per-lane write mask, bit j for lane j |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_illegal | output | 1 | Last operation was illegal |
| dst_data | output | 512 | Destination register |

## Verification
The assertions check the handshake on every cycle: the result holds under back-pressure, a result follows every acceptance, and an illegal operation leaves the destination untouched. They also check that the 256-bit-tuple and reserved-field rules raise the flag, and that a legal 128-bit operation clears the upper bits. Lane routing needs the bench's scenarios and its reference model to show. That covers which source element reaches which lane for each tuple count and element width, merge versus zero for unselected lanes, and that mask bits above the lane count are ignored.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_RSVD = 2'd3
  } len_e;

  typedef enum logic [1:0] {
    TUP_1 = 2'd0,
    TUP_2 = 2'd1,
    TUP_4 = 2'd2,
    TUP_8 = 2'd3
  } tup_e;

  localparam logic [3:0] RSV_OK = 4'b1111;

  // element count of a tuple code
  function automatic int tup_count(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/vbc_legality.sv
module vbc_legality
  import vbc_pkg::*;
#(
  parameter int SLOT_W    = 32,
  parameter int SRC_W     = 256,
  parameter int NSLOT     = 16,
  parameter int BASE_SLOT = 4,
  localparam int ACT_W    = $clog2(NSLOT + 1)
) (
  input  logic [1:0]       len_sel,
  input  logic [1:0]       tup_sel,
  input  logic             elem64,
  input  logic             masked,
  input  logic             reg_src,
  input  logic [3:0]       rsv,
  output logic             illegal,
  output logic [ACT_W-1:0] act_slots
);
  int   tup_bits;
  logic short_len;
  logic tup_wide;
  logic tup_mid;
  logic single64;
  logic bad_len;
  logic bad_reg;

  always_comb begin
    tup_bits  = tup_count(tup_sel) * (elem64 ? 2 * SLOT_W : SLOT_W);
    short_len = (len_e'(len_sel) == LEN_128);
    tup_wide  = (tup_bits == 8 * SLOT_W);
    tup_mid   = (tup_bits == 4 * SLOT_W);
    single64  = elem64 && (tup_e'(tup_sel) == TUP_1);

    bad_len = (len_e'(len_sel) == LEN_RSVD)
           || (tup_bits > SRC_W)
           || (short_len && (single64 || (tup_e'(tup_sel) != TUP_1)))
           || (tup_wide && (len_e'(len_sel) != LEN_512));

    bad_reg = !masked && reg_src && (single64 || tup_mid);

    illegal = bad_len || bad_reg || (rsv != RSV_OK);

    case (len_e'(len_sel))
      LEN_128: act_slots = ACT_W'(BASE_SLOT);
      LEN_256: act_slots = ACT_W'(2 * BASE_SLOT);
      LEN_512: act_slots = ACT_W'(4 * BASE_SLOT);
      default: act_slots = '0;
    endcase
  end
endmodule

// File: rtl/vbc_slot.sv
module vbc_slot #(
  parameter int SLOT_IDX  = 0,
  parameter int SLOT_W    = 32,
  parameter int SRC_SLOTS = 8,
  parameter int MASK_W    = 16,
  parameter int ACT_W     = 5,
  localparam int IDX_W    = $clog2(SRC_SLOTS),
  localparam int LANE32   = SLOT_IDX % SRC_SLOTS,
  localparam int LANE64   = (SLOT_IDX / 2) % (SRC_SLOTS / 2),
  localparam int HALF     = SLOT_IDX % 2
) (
  input  logic [SRC_SLOTS*SLOT_W-1:0] src_data,
  input  logic [1:0]                  tup_sel,
  input  logic                        elem64,
  input  logic                        masked,
  input  logic                        zero_mode,
  input  logic [MASK_W-1:0]           lane_mask,
  input  logic [ACT_W-1:0]            act_slots,
  input  logic [SLOT_W-1:0]           old_val,
  output logic [SLOT_W-1:0]           new_val
);
  int               tmask;
  logic [IDX_W-1:0] sel;
  logic [SLOT_W-1:0] pick;
  logic             active;
  logic             take;

  always_comb begin
    tmask = (1 << tup_sel) - 1;
    if (elem64) sel = IDX_W'(((LANE64 & tmask) << 1) | HALF);
    else        sel = IDX_W'(LANE32 & tmask);

    pick = '0;
    for (int k = 0; k < SRC_SLOTS; k++)
      if (sel == IDX_W'(k)) pick = src_data[k*SLOT_W +: SLOT_W];

    active = ACT_W'(SLOT_IDX) < act_slots;
    take   = !masked || (elem64 ? lane_mask[SLOT_IDX/2] : lane_mask[SLOT_IDX]);

    if (!active)       new_val = '0;
    else if (take)     new_val = pick;
    else if (zero_mode) new_val = '0;
    else               new_val = old_val;
  end
endmodule

// File: rtl/vec_bcast_unit.sv
module vec_bcast_unit
  import vbc_pkg::*;
#(
  parameter int VMAX_W = 512,
  parameter int SRC_W  = 256,
  parameter int SLOT_W = 32,
  localparam int NSLOT     = VMAX_W / SLOT_W,
  localparam int SRC_SLOTS = SRC_W / SLOT_W,
  localparam int MASK_W    = NSLOT,
  localparam int BASE_SLOT = NSLOT / 4,
  localparam int ACT_W     = $clog2(NSLOT + 1),
  localparam int LOW_W     = BASE_SLOT * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  src_data,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        tup_sel,
  input  logic              elem64,
  input  logic              masked,
  input  logic              zero_mode,
  input  logic              reg_src,
  input  logic [3:0]        rsv,
  input  logic [MASK_W-1:0] lane_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_illegal,
  output logic [VMAX_W-1:0] dst_data
);
  logic              ill_w;
  logic [ACT_W-1:0]  act_slots;
  logic [VMAX_W-1:0] next_dst;
  logic [VMAX_W-1:0] dst_q;
  logic              vld_q;
  logic              ill_q;
  logic              accept;

  vbc_legality #(
    .SLOT_W(SLOT_W), .SRC_W(SRC_W), .NSLOT(NSLOT), .BASE_SLOT(BASE_SLOT)
  ) u_legal (
    .len_sel(len_sel), .tup_sel(tup_sel), .elem64(elem64), .masked(masked),
    .reg_src(reg_src), .rsv(rsv), .illegal(ill_w), .act_slots(act_slots)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    vbc_slot #(
      .SLOT_IDX(s), .SLOT_W(SLOT_W), .SRC_SLOTS(SRC_SLOTS),
      .MASK_W(MASK_W), .ACT_W(ACT_W)
    ) u_slot (
      .src_data(src_data), .tup_sel(tup_sel), .elem64(elem64),
      .masked(masked), .zero_mode(zero_mode), .lane_mask(lane_mask),
      .act_slots(act_slots), .old_val(dst_q[s*SLOT_W +: SLOT_W]),
      .new_val(next_dst[s*SLOT_W +: SLOT_W])
    );
  end

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q <= '0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else if (accept) begin
      vld_q <= 1'b1;
      ill_q <= ill_w;
      if (!ill_w) dst_q <= next_dst;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid   = vld_q;
  assign out_illegal = ill_q;
  assign dst_data    = dst_q;

  // R12: a stalled result holds
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst_data) && $stable(out_illegal)));

  // R12: no pending result means the input is open
  p_idle_ready_r12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R11: acceptance produces a result next cycle
  p_result_next_r11: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R11: illegal operations leave the destination alone
  p_ill_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (accept && ill_w) |=> ($stable(dst_data) && out_illegal));

  // R9: reserved field misuse is flagged
  p_rsv_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv != RSV_OK) |-> ill_w);

  // R8: 256-bit tuple of 32-bit elements below full length is flagged
  p_wide_tuple_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !elem64 && tup_e'(tup_sel) == TUP_8 && len_e'(len_sel) != LEN_512) |-> ill_w);

  // R6: a legal short-length result has a clear upper part
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !ill_w && len_e'(len_sel) == LEN_128) |=> (dst_data[VMAX_W-1:LOW_W] == '0));
endmodule

// File: tb/vec_bcast_unit_test.sv
module vec_bcast_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] src_data = '0;
  logic [1:0]   len_sel = 2'd0;
  logic [1:0]   tup_sel = 2'd0;
  logic         elem64 = 1'b0;
  logic         masked = 1'b0;
  logic         zero_mode = 1'b0;
  logic         reg_src = 1'b0;
  logic [3:0]   rsv = 4'hF;
  logic [15:0]  lane_mask = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_illegal;
  logic [511:0] dst_data;

  always #5 clk = ~clk;

  vec_bcast_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_data(src_data), .len_sel(len_sel), .tup_sel(tup_sel),
    .elem64(elem64), .masked(masked), .zero_mode(zero_mode),
    .reg_src(reg_src), .rsv(rsv), .lane_mask(lane_mask),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_illegal(out_illegal), .dst_data(dst_data)
  );

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string cur_tag = "R11";

  // reference state
  logic [511:0] m_dst = '0;
  logic         m_vld = 1'b0;
  logic         m_ill = 1'b0;
  logic         m_acc = 1'b0;

  function automatic logic ref_illegal(input logic [1:0] ln, input logic [1:0] tp,
      input logic e64, input logic msk, input logic rs, input logic [3:0] rv);
    int bits;
    logic r;
    bits = (1 << tp) * (e64 ? 64 : 32);
    r = 1'b0;
    if (rv != 4'hF) r = 1'b1;
    if (ln == 2'd3) r = 1'b1;
    if (bits > 256) r = 1'b1;
    if (ln == 2'd0 && (e64 || tp != 2'd0)) r = 1'b1;
    if (bits == 256 && ln != 2'd2) r = 1'b1;
    if (!msk && rs && ((e64 && tp == 2'd0) || bits == 128)) r = 1'b1;
    return r;
  endfunction

  function automatic logic [511:0] ref_dst(input logic [511:0] old,
      input logic [255:0] src, input logic [1:0] ln, input logic [1:0] tp,
      input logic e64, input logic msk, input logic zm, input logic [15:0] mk);
    logic [511:0] r;
    int lenb, ew, per, t, nl;
    r = '0;
    lenb = 128 << ln;
    ew = e64 ? 64 : 32;
    per = ew / 32;
    t = 1 << tp;
    nl = lenb / ew;
    for (int j = 0; j < nl; j++) begin
      for (int h = 0; h < per; h++) begin
        int ds, ss;
        ds = j * per + h;
        ss = (j % t) * per + h;
        if (!msk || mk[j]) r[ds*32 +: 32] = src[ss*32 +: 32];
        else if (zm)       r[ds*32 +: 32] = 32'h0;
        else               r[ds*32 +: 32] = old[ds*32 +: 32];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dst = '0; m_vld = 1'b0; m_ill = 1'b0; m_acc = 1'b0;
    end else begin
      m_acc = in_valid && (!m_vld || out_ready);
      if (m_acc) begin
        m_vld = 1'b1;
        m_ill = ref_illegal(len_sel, tup_sel, elem64, masked, reg_src, rsv);
        if (!m_ill)
          m_dst = ref_dst(m_dst, src_data, len_sel, tup_sel, elem64, masked, zero_mode, lane_mask);
      end else if (out_ready) begin
        m_vld = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [511:0] act,
      input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compared on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_tag, "dst_data", dst_data, m_dst);
      check("R12", "out_valid", {511'b0, out_valid}, {511'b0, m_vld});
      check("R12", "in_ready", {511'b0, in_ready}, {511'b0, (!m_vld || out_ready)});
      if (m_vld) check(cur_tag, "out_illegal", {511'b0, out_illegal}, {511'b0, m_ill});
    end
  end

  task automatic issue(input string tag, input logic [255:0] s, input logic [1:0] ln,
      input logic [1:0] tp, input logic e64, input logic msk, input logic zm,
      input logic rs, input logic [3:0] rv, input logic [15:0] mk, input logic exp_ill);
    @(negedge clk);
    cur_tag = tag;
    src_data = s; len_sel = ln; tup_sel = tp; elem64 = e64; masked = msk;
    zero_mode = zm; reg_src = rs; rsv = rv; lane_mask = mk; in_valid = 1'b1;
    @(posedge clk); #1;
    while (!m_acc) begin @(posedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, "illegal flag", {511'b0, out_illegal}, {511'b0, exp_ill});
  endtask

  logic [255:0] pat_a;
  logic [255:0] pat_b;
  logic [511:0] snap;

  initial begin
    for (int e = 0; e < 8; e++) begin
      pat_a[e*32 +: 32] = 32'hA0000000 + 32'(e) * 32'h01010101;
      pat_b[e*32 +: 32] = 32'h5C000000 + 32'(e) * 32'h00110011;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "reset dst", dst_data, '0);
    check("R11", "reset valid", {511'b0, out_valid}, '0);

    // R5: unmasked, mask and zero_mode ignored
    issue("R5", pat_a, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 16'h0000, 1'b0);
    check("R5", "all lanes elem0", dst_data, {16{pat_a[31:0]}});
    // R1: pairs at 256, merge keeps odd lanes
    issue("R3", pat_b, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 16'h0055, 1'b0);
    // R4: 4-tuple zero mode at 512
    issue("R4", pat_a, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 16'hF0F3, 1'b0);
    // R1: 8-tuple at 512, full mask
    issue("R1", pat_b, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 16'hFFFF, 1'b0);
    check("R1", "lane 9 = elem1", {480'b0, dst_data[9*32 +: 32]}, {480'b0, pat_b[63:32]});
    // R2: 64-bit elements
    issue("R2", pat_a, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b0);
    issue("R2", pat_b, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 16'h00B7, 1'b0);
    issue("R2", pat_a, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 16'h00EE, 1'b0);
    check("R2", "lane 5 = qword1", {448'b0, dst_data[5*64 +: 64]}, {448'b0, pat_a[127:64]});
    // R6: short lengths clear upper bits, high mask bits ignored
    issue("R6", pat_b, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 1'b0);
    check("R6", "upper clear", {128'b0, dst_data[511:128]}, '0);
    issue("R6", pat_a, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 16'hFFF5, 1'b0);
    issue("R6", pat_b, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 16'hFFF9, 1'b0);
    // illegal combinations; destination must not move
    snap = dst_data;
    issue("R7", pat_a, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 16'hFFFF, 1'b1);
    issue("R7", pat_a, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b1);
    issue("R7", pat_a, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b1);
    issue("R8", pat_a, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 16'hFFFF, 1'b1);
    issue("R8", pat_a, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b1);
    issue("R8", pat_a, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b1);
    issue("R9", pat_a, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hE, 16'h0000, 1'b1);
    issue("R10", pat_a, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 1'b1);
    issue("R10", pat_a, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 1'b1);
    issue("R10", pat_a, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 1'b1);
    check("R11", "dst kept after illegal", dst_data, snap);
    issue("R10", pat_b, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 16'h0000, 1'b0);
    issue("R8", pat_b, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 1'b0);
    // R12: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    issue("R12", pat_a, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 16'h00A5, 1'b0);
    snap = dst_data;
    @(negedge clk);
    cur_tag = "R12";
    src_data = pat_b; len_sel = 2'd2; tup_sel = 2'd0; elem64 = 1'b0; masked = 1'b0;
    rsv = 4'hF; reg_src = 1'b0; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "held while stalled", dst_data, snap);
    check("R12", "ready low", {511'b0, in_ready}, '0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12", "taken after release", dst_data, {16{pat_b[31:0]}});
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule